// File: doc/BRIEF.md
# SPI NOR Range Erase Sequencer

This block clears a range of a serial NOR flash without help from software. One start pulse loads a 24-bit byte address and a byte length. The block then works through the range one erase unit at a time. For each unit it reads the flash status until the device reports that it is no longer busy. It then sets the write-enable latch in a separate transaction and sends the erase command with the unit's address. It moves the address forward by one unit and takes one unit off the remaining length, and it repeats this until the length reaches zero.

The `small_mode` input picks the erase granule for the whole run. When it is set, the block uses 4 KiB blocks. When it is clear, it uses full sectors, whose size is a parameter (64 KiB by default). A range that does not line up with the chosen granule is refused before any flash traffic. A device that stays busy longer than `busy_limit` clock cycles while the block polls it ends the run with a timeout flag. A simple mode-0 byte shifter inside the block drives the SPI pins.

The block has no data stream: start, configuration and result are plain level and pulse signals. `start` is sampled only while `busy` is low.

Top module: `nor_erase_seq`

## Requirements
- R1: Before every erase unit, the block sends status reads (opcode 0x05 followed by one dummy byte; the second byte received is the status). It repeats them until status bit 0 reads 0. Status bits 2 to 7 have no effect on the sequence.
- R2: After the status read that shows the device idle, the block sends write enable (0x06) as a one-byte transaction of its own, before each erase command.
- R3: An erase transaction is exactly four bytes: the opcode, then address bits 23:16, 15:8 and 7:0.
- R4: With `small_mode` high the erase opcode is 0x20 and the stride is 4096 bytes. With it low the opcode is 0xD8 and the stride is 2^LARGE_LOG2 bytes (65536 by default).
- R5: Unit addresses are start, start+stride, and so on, one per stride in the length. `done` is high for exactly one cycle when the run ends. A zero length gives `done` with no flash traffic. `spi_cs_n` is high whenever `busy` is low.
- R6: Between any two transactions, `spi_cs_n` stays high for at least one SPI clock period (2*SCK_HALF clock cycles).
- R7: The block counts clock cycles while it polls for one unit. If a status read completes with bit 0 set and the count has reached `busy_limit`, the block raises `err_timeout` together with `done`, returns to idle and sends nothing more.
- R8: If the address or the length is not a multiple of the selected stride, the block raises `err_align` together with `done` and sends no command. `err_align` and `err_timeout` are never high together.
- R9: The SPI pins use mode 0, most significant bit first. `spi_sclk` idles low while chip select is high, `spi_mosi` holds steady while `spi_sclk` is high, and `spi_miso` is sampled on the rising edge.
- R10: A start pulse while `busy` is high is ignored. An accepted start clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| start_addr | input | ADDR_W | First byte address of the range |
| erase_len | input | ADDR_W+1 | Range length in bytes |
| small_mode | input | 1 | 1: 4 KiB blocks, 0: large sectors |
| busy_limit | input | LIMIT_W | Polling time limit per unit, in clock cycles |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_align | output | 1 | Range refused for misalignment |
| err_timeout | output | 1 | Device stayed busy past the limit |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
On every cycle, the assertions check the pin-level rules: the SPI clock idles low with chip select high, MOSI holds while the clock is high, and chip select stays high for a minimum gap between transactions. They also check that `done` lasts one cycle, that chip select stays inactive while the block is idle or refusing a range, and that a timeout arrives together with `done`. Only the bench's flash model can show the content of the transactions. That covers opcodes and address bytes, the stride in each mode, the number of status polls per unit, that write enable comes before every erase, and that a start pulse during a run changes nothing.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

  localparam logic [7:0] CMD_STATUS   = 8'h05;
  localparam logic [7:0] CMD_WENABLE  = 8'h06;
  localparam logic [7:0] CMD_ERASE_SM = 8'h20;
  localparam logic [7:0] CMD_ERASE_LG = 8'hD8;
  localparam int         FRAME_ADDR_W = 24;

  typedef enum logic [1:0] {
    OP_STATUS  = 2'd0,
    OP_WENABLE = 2'd1,
    OP_ERASE   = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LAUNCH = 3'd1,
    ST_XFER   = 3'd2,
    ST_GAP    = 3'd3,
    ST_FINISH = 3'd4
  } seq_state_e;

  // index of the final byte in each transaction
  function automatic logic [1:0] frame_last(input op_e op);
    case (op)
      OP_STATUS:  frame_last = 2'd1;
      OP_WENABLE: frame_last = 2'd0;
      default:    frame_last = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/nor_spi_byte_shifter.sv
module nor_spi_byte_shifter #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       done
);
  localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(SCK_HALF - 1);

  logic [7:0]       tx_q, rx_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] div_q;
  logic             act_q, sclk_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !act_q) begin
        tx_q   <= tx_byte;
        act_q  <= 1'b1;
        bit_q  <= '0;
        div_q  <= '0;
        sclk_q <= 1'b0;
      end else if (act_q) begin
        if (div_q == DIV_END) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;                  // rising edge: capture
            rx_q   <= {rx_q[6:0], miso};
          end else begin
            sclk_q <= 1'b0;                  // falling edge: next bit out
            tx_q   <= {tx_q[6:0], 1'b0};
            bit_q  <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];
  assign rx_byte = rx_q;
  assign done    = done_q;
endmodule

// File: rtl/nor_erase_geometry.sv
module nor_erase_geometry #(
  parameter int ADDR_W     = 24,
  parameter int SMALL_LOG2 = 12,
  parameter int LARGE_LOG2 = 16
) (
  input  logic              small_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W:0]   len,
  output logic [ADDR_W:0]   stride,
  output logic [7:0]        opcode,
  output logic              aligned,
  output logic              zero_len
);
  import nor_erase_pkg::*;
  localparam int LEN_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0] SMALL_STRIDE = LEN_W'(1) << SMALL_LOG2;
  localparam logic [LEN_W-1:0] LARGE_STRIDE = LEN_W'(1) << LARGE_LOG2;

  logic [LEN_W-1:0] mask;
  logic [LEN_W-1:0] span;

  always_comb begin
    if (small_mode) begin
      stride = SMALL_STRIDE;
      opcode = CMD_ERASE_SM;
    end else begin
      stride = LARGE_STRIDE;
      opcode = CMD_ERASE_LG;
    end
    mask     = stride - LEN_W'(1);
    span     = {1'b0, addr} | len;
    aligned  = (span & mask) == '0;
    zero_len = (len == '0);
  end
endmodule

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl #(
  parameter int ADDR_W   = 24,
  parameter int LIMIT_W  = 16,
  parameter int SCK_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [ADDR_W:0]    erase_len,
  input  logic [LIMIT_W-1:0] busy_limit,
  input  logic [ADDR_W:0]    geo_stride,
  input  logic [7:0]         geo_opcode,
  input  logic               geo_aligned,
  input  logic               geo_zero,
  input  logic               sh_done,
  input  logic [7:0]         sh_rx,
  output logic               sh_go,
  output logic [7:0]         sh_tx,
  output logic               cs_n,
  output logic               busy,
  output logic               done,
  output logic               err_align,
  output logic               err_timeout
);
  import nor_erase_pkg::*;
  localparam int LEN_W   = ADDR_W + 1;
  localparam int GAP_CYC = 2 * SCK_HALF;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_END = GAP_W'(GAP_CYC - 1);

  seq_state_e         state_q;
  op_e                op_q;
  logic [1:0]         idx_q, nxt_idx;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   left_q, stride_q;
  logic [7:0]         opcode_q;
  logic [LIMIT_W-1:0] poll_q;
  logic [GAP_W-1:0]   gap_q;
  logic               cs_q, errt_q, erra_q;
  logic               last_byte;
  logic [FRAME_ADDR_W-1:0] frame_addr;

  assign last_byte  = (idx_q == frame_last(op_q));
  assign nxt_idx    = (state_q == ST_LAUNCH) ? 2'd0 : idx_q + 2'd1;
  assign frame_addr = FRAME_ADDR_W'(addr_q);
  assign sh_go      = (state_q == ST_LAUNCH) ||
                      (state_q == ST_XFER && sh_done && !last_byte);

  always_comb begin
    case (op_q)
      OP_STATUS:  sh_tx = (nxt_idx == 2'd0) ? CMD_STATUS : 8'h00;
      OP_WENABLE: sh_tx = CMD_WENABLE;
      default: begin
        case (nxt_idx)
          2'd0:    sh_tx = opcode_q;
          2'd1:    sh_tx = frame_addr[23:16];
          2'd2:    sh_tx = frame_addr[15:8];
          default: sh_tx = frame_addr[7:0];
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_STATUS;
      idx_q    <= '0;
      addr_q   <= '0;
      left_q   <= '0;
      stride_q <= '0;
      opcode_q <= '0;
      poll_q   <= '0;
      gap_q    <= '0;
      cs_q     <= 1'b1;
      errt_q   <= 1'b0;
      erra_q   <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && op_q == OP_STATUS && poll_q != '1)
        poll_q <= poll_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            errt_q   <= 1'b0;
            erra_q   <= 1'b0;
            addr_q   <= start_addr;
            left_q   <= erase_len;
            stride_q <= geo_stride;
            opcode_q <= geo_opcode;
            op_q     <= OP_STATUS;
            poll_q   <= '0;
            if (!geo_aligned) begin
              erra_q  <= 1'b1;
              state_q <= ST_FINISH;
            end else if (geo_zero) begin
              state_q <= ST_FINISH;
            end else begin
              state_q <= ST_LAUNCH;
            end
          end
        end
        ST_LAUNCH: begin
          cs_q    <= 1'b0;
          idx_q   <= '0;
          state_q <= ST_XFER;
        end
        ST_XFER: begin
          if (sh_done) begin
            if (!last_byte) begin
              idx_q <= idx_q + 2'd1;
            end else begin
              cs_q    <= 1'b1;
              gap_q   <= '0;
              state_q <= ST_GAP;
              case (op_q)
                OP_STATUS: begin
                  if (!sh_rx[0]) begin
                    op_q <= OP_WENABLE;
                  end else if (poll_q >= busy_limit) begin
                    errt_q  <= 1'b1;
                    state_q <= ST_FINISH;
                  end
                end
                OP_WENABLE: op_q <= OP_ERASE;
                default: begin
                  addr_q <= addr_q + ADDR_W'(stride_q);
                  left_q <= left_q - stride_q;
                  op_q   <= OP_STATUS;
                  poll_q <= '0;
                  if (left_q == stride_q) state_q <= ST_FINISH;
                end
              endcase
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_END) state_q <= ST_LAUNCH;
          else                  gap_q   <= gap_q + 1'b1;
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n        = cs_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_FINISH);
  assign err_align   = erra_q;
  assign err_timeout = errt_q;
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
  parameter int ADDR_W     = 24,
  parameter int SMALL_LOG2 = 12,
  parameter int LARGE_LOG2 = 16,
  parameter int LIMIT_W    = 16,
  parameter int SCK_HALF   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [ADDR_W:0]    erase_len,
  input  logic               small_mode,
  input  logic [LIMIT_W-1:0] busy_limit,
  output logic               busy,
  output logic               done,
  output logic               err_align,
  output logic               err_timeout,
  output logic               spi_sclk,
  output logic               spi_cs_n,
  output logic               spi_mosi,
  input  logic               spi_miso
);
  localparam int LEN_W = ADDR_W + 1;

  logic [LEN_W-1:0] geo_stride;
  logic [7:0]       geo_opcode;
  logic             geo_aligned, geo_zero;
  logic             sh_go, sh_done;
  logic [7:0]       sh_tx, sh_rx;

  nor_erase_geometry #(
    .ADDR_W(ADDR_W), .SMALL_LOG2(SMALL_LOG2), .LARGE_LOG2(LARGE_LOG2)
  ) geo_i (
    .small_mode(small_mode), .addr(start_addr), .len(erase_len),
    .stride(geo_stride), .opcode(geo_opcode),
    .aligned(geo_aligned), .zero_len(geo_zero)
  );

  nor_erase_ctrl #(
    .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .SCK_HALF(SCK_HALF)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .erase_len(erase_len), .busy_limit(busy_limit),
    .geo_stride(geo_stride), .geo_opcode(geo_opcode),
    .geo_aligned(geo_aligned), .geo_zero(geo_zero),
    .sh_done(sh_done), .sh_rx(sh_rx), .sh_go(sh_go), .sh_tx(sh_tx),
    .cs_n(spi_cs_n), .busy(busy), .done(done),
    .err_align(err_align), .err_timeout(err_timeout)
  );

  nor_spi_byte_shifter #(.SCK_HALF(SCK_HALF)) shift_i (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx_byte(sh_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(sh_rx), .done(sh_done)
  );
endmodule

// File: rtl/nor_erase_chk.sv
module nor_erase_chk #(
  parameter int SCK_HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic done,
  input logic busy,
  input logic err_align,
  input logic err_timeout
);
  localparam int GAP   = 2 * SCK_HALF;
  localparam int CNT_W = $clog2(GAP + 1);
  localparam logic [CNT_W-1:0] GAP_V = CNT_W'(GAP);

  logic [CNT_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hi_cnt <= GAP_V;
    else if (!cs_n)           hi_cnt <= '0;
    else if (hi_cnt != GAP_V) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);                                          // R9
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));                                  // R9
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= GAP_V);                         // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                          // R5
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);                                          // R5
  AST_ALIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_align |-> cs_n);                                      // R8
  AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> (done && cs_n));                   // R7
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_align && err_timeout));                             // R8
endmodule

bind nor_erase_seq nor_erase_chk #(.SCK_HALF(SCK_HALF)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .mosi(spi_mosi), .done(done), .busy(busy),
  .err_align(err_align), .err_timeout(err_timeout)
);

// File: tb/nor_erase_seq_tb_top.sv
module nor_erase_seq_tb_top;
  localparam int SCK_HALF = 2;
  localparam int NV = 8;
  // {small, addr[24], len[25], polls[4], limit[16], kind[2], units[8]}
  // kind: 0 ok, 1 alignment refusal, 2 timeout
  localparam logic [79:0] VEC [NV] = '{
    {1'b1, 24'h001000, 25'h0003000, 4'd2,  16'd5000, 2'd0, 8'd3},
    {1'b0, 24'h020000, 25'h0020000, 4'd0,  16'd5000, 2'd0, 8'd2},
    {1'b1, 24'h000800, 25'h0001000, 4'd0,  16'd5000, 2'd1, 8'd0},
    {1'b0, 24'h010000, 25'h0001000, 4'd0,  16'd5000, 2'd1, 8'd0},
    {1'b1, 24'h000000, 25'h0000000, 4'd0,  16'd5000, 2'd0, 8'd0},
    {1'b1, 24'hFFF000, 25'h0001000, 4'd1,  16'd5000, 2'd0, 8'd1},
    {1'b0, 24'h0F0000, 25'h0010000, 4'd3,  16'd5000, 2'd0, 8'd1},
    {1'b0, 24'h000000, 25'h0010000, 4'd15, 16'd100,  2'd2, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [24:0] erase_len = '0;
  logic small_mode = 1'b0;
  logic [15:0] busy_limit = '0;
  logic busy, done, err_align, err_timeout;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #10 clk = ~clk;

  nor_erase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .erase_len(erase_len), .small_mode(small_mode), .busy_limit(busy_limit),
    .busy(busy), .done(done), .err_align(err_align), .err_timeout(err_timeout),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- flash model ----------------
  logic [7:0]  sh = '0;
  logic [7:0]  frame [4];
  int          nbits = 0, tx_bytes = 0, out_idx = 0;
  bit          rd_mode = 0, wel = 0;
  int          busy_left = 0, polls_cfg = 0;
  logic [7:0]  er_op [16];
  logic [23:0] er_addr [16];
  int          n_er = 0, n_rdsr = 0, n_wren = 0, model_err = 0;
  int          hi_cnt = 0, min_gap = 1000000;
  logic        prev_cs = 1'b1;

  function automatic logic [7:0] status_byte();
    return {6'b101101, wel, (busy_left > 0)};
  endfunction

  always @(negedge spi_cs_n) begin
    nbits = 0; tx_bytes = 0; rd_mode = 0; out_idx = 0;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    nbits++;
    if (nbits % 8 == 0) begin
      if (tx_bytes < 4) frame[tx_bytes] = sh;
      if (tx_bytes == 0 && sh == 8'h05) rd_mode = 1;
      tx_bytes++;
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n && rd_mode) begin
    spi_miso = status_byte()[7 - out_idx];
    out_idx = (out_idx + 1) % 8;
  end

  always @(posedge spi_cs_n) if (tx_bytes > 0) begin
    case (frame[0])
      8'h05: begin
        n_rdsr++;
        if (busy_left > 0) busy_left--;
      end
      8'h06: begin
        if (tx_bytes == 1) begin wel = 1; n_wren++; end
        else model_err++;
      end
      8'h20, 8'hD8: begin
        if (tx_bytes != 4 || !wel) model_err++;
        else begin
          if (n_er < 16) begin
            er_op[n_er]   = frame[0];
            er_addr[n_er] = {frame[1], frame[2], frame[3]};
          end
          n_er++;
          busy_left = polls_cfg;
        end
        wel = 0;
      end
      default: model_err++;
    endcase
    tx_bytes = 0;
  end

  always @(posedge clk) begin
    if (spi_cs_n) hi_cnt++;
    else begin
      if (prev_cs && hi_cnt < min_gap) min_gap = hi_cnt;
      hi_cnt = 0;
    end
    prev_cs = spi_cs_n;
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_one(input bit sm, input logic [23:0] a,
                         input logic [24:0] l, input int polls,
                         input logic [15:0] lim, input int kind,
                         input int units, input int inject_at);
    int cyc;
    longint stride;
    @(negedge clk);
    small_mode = sm; start_addr = a; erase_len = l; busy_limit = lim;
    polls_cfg = polls; busy_left = polls; wel = 0;
    n_er = 0; n_rdsr = 0; n_wren = 0; model_err = 0; min_gap = 1000000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (inject_at != 0 && cyc == inject_at) begin
        // R10: a second request in mid-run must change nothing
        start_addr = 24'h100000; erase_len = 25'h1000; small_mode = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc++;
      end
    end
    chk("R5", "done seen", done, 1);
    chk("R8", "err_align", err_align, (kind == 1));
    chk("R7", "err_timeout", err_timeout, (kind == 2));
    @(negedge clk);
    chk("R5", "busy after done", busy, 0);
    chk("R5", "cs_n after done", spi_cs_n, 1);
    stride = sm ? 64'h1000 : 64'h10000;
    chk("R5", "unit count", n_er, units);
    for (int i = 0; i < units && i < 16; i++) begin
      chk("R4", "erase opcode", er_op[i], sm ? 8'h20 : 8'hD8);
      chk("R3", "erase address", er_addr[i], (a + i * stride) & 64'hFFFFFF);
    end
    chk("R2", "write enables", n_wren, units);
    chk("R2", "model protocol errors", model_err, 0);
    if (kind == 0)
      chk("R1", "status polls", n_rdsr, units * (polls + 1));
    if (kind == 1)
      chk("R8", "no traffic on refusal", n_rdsr + n_wren + n_er, 0);
    if (n_rdsr + n_wren + n_er > 1)
      chk("R6", "min cs gap ok", (min_gap >= 2 * SCK_HALF), 1);
    if (kind == 2) begin
      repeat (300) @(negedge clk);
      chk("R7", "no traffic after timeout", n_rdsr, 2);
      chk("R7", "still idle", busy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R9", "reset sclk", spi_sclk, 0);
    chk("R5", "reset cs_n", spi_cs_n, 1);
    chk("R5", "reset done", done, 0);
    chk("R10", "reset busy", busy, 0);
    chk("R8", "reset err_align", err_align, 0);
    chk("R7", "reset err_timeout", err_timeout, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_one(VEC[v][79], VEC[v][78:55], VEC[v][54:30], int'(VEC[v][29:26]),
              VEC[v][25:10], int'(VEC[v][9:8]), int'(VEC[v][7:0]), 0);
    end

    // R10: zero-length run right after a timeout clears the flag
    run_one(1'b1, 24'h000000, 25'h0, 0, 16'd5000, 0, 0, 0);
    // R10: start pulse in mid-run is ignored
    run_one(1'b0, 24'h040000, 25'h0020000, 1, 16'd5000, 0, 2, 150);
    // R1: a status with only bit 0 clear but high bits set must proceed
    run_one(1'b1, 24'h00A000, 25'h0001000, 0, 16'd5000, 0, 1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule